// File: doc/BRIEF.md
# Two-Phase Latch Pipeline

This block is a linear chain of storage stages that carries single-rail data words from a producer to a consumer under transition signalling. Each stage holds one latch bank and a controller made of a single XNOR gate. A stage keeps its latch open while its own request phase equals the acknowledge phase returned by the next stage. A new item toggles the stage's request, which closes the latch. When the next stage takes the item and toggles its own request, which is also its acknowledge backward, the latch opens again. An empty chain is fully open, so a word flows straight toward the output. A stalled chain fills until every stage holds its own item.

The model is cycle-accurate and uses a sampling clock. An open stage takes its input on every rising edge, so an item moves forward one stage per cycle. The forward signal is a level that changes once per item. There is no separate valid/ready pair. Back-pressure works as follows:
- The producer may present a new word and toggle `up_req` only when `up_req` equals `up_ack`. It must then hold `up_data` until `up_ack` matches again.
- The consumer sees a pending word whenever `dn_req` differs from `dn_ack`. It takes the word by toggling `dn_ack`. Holding `dn_ack` back stalls the chain.

Top module: `tpp_pipeline`

## Requirements
- R1: While reset is held, `dn_req`, `up_ack` and `dn_data` are all 0.
- R2: In an empty chain, a toggle of `up_req` appears as a toggle of `dn_req` exactly DEPTH rising edges later, with the matching word on `dn_data`.
- R3: The stage nearest the producer captures a new word on the first rising edge after the `up_req` toggle, if that stage is open. `up_ack` then equals `up_req`, which tells the producer it may send again.
- R4: A stage whose request phase differs from the acknowledge phase returned by its successor keeps its word and request phase unchanged. Its latch enable is the XNOR of those two phases.
- R5: Every word accepted at the input is delivered at the output once, without loss, in the order of acceptance, under any pattern of producer gaps and consumer stalls.
- R6: With the consumer stalled, exactly DEPTH words are accepted. The next toggle of `up_req` gets no matching `up_ack` until the consumer acknowledges.
- R7: `dn_data` stays unchanged while `dn_req` differs from `dn_ack`.
- R8: `dn_req` does not toggle again while a word is pending, so each word is offered once. Successive words alternate the polarity of the toggle.
- R9: In free flow, with a producer and consumer that answer at once, one word is accepted every 2 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock; stages update on the rising edge |
| rst_n | input | 1 | Active-low asynchronous reset; clears all phases and data |
| up_data | input | WIDTH | Word from the producer, held while a send is open |
| up_req | input | 1 | Producer request phase; one toggle per word |
| up_ack | output | 1 | Acknowledge phase to the producer; equals the first stage's request phase |
| dn_data | output | WIDTH | Word held by the last stage |
| dn_req | output | 1 | Request phase of the last stage toward the consumer |
| dn_ack | input | 1 | Consumer acknowledge phase; one toggle per word taken |

## Verification
The bench targets the fill and drain corners:
- A stalled consumer with the producer pushing past capacity. A controller with the XNOR polarity inverted, or one that ignores the successor's phase, would overwrite a held word or accept a DEPTH+1th word. The ordered drain that follows would then show a lost or repeated word.
- An empty chain. A stage that adds a cycle or skips one would move the delivery edge away from exactly DEPTH.
- A free-flowing stream. Measuring the interval between acceptances exposes a controller that leaves a latch closed for a cycle too long.
- Long random runs that mix producer gaps with consumer stalls. These catch words delivered out of order or twice at phase changes.

// File: rtl/tpp_pkg.sv
package tpp_pkg;

  // Latch gate states as seen by a stage's data bank.
  typedef enum logic {
    GATE_HOLD = 1'b0,
    GATE_OPEN = 1'b1
  } gate_e;

  // Phases agree: the stage's last item was taken downstream, or none arrived yet.
  function automatic gate_e gate_from_phases(input logic own_phase, input logic next_phase);
    return (own_phase ~^ next_phase) ? GATE_OPEN : GATE_HOLD;
  endfunction

endpackage

// File: rtl/tpp_stage_ctrl.sv
module tpp_stage_ctrl
  import tpp_pkg::*;
(
  input  logic  own_req,
  input  logic  next_ack,
  output gate_e gate
);

  // The single-gate local controller: XNOR of own request and successor ack.
  always_comb begin
    gate = gate_from_phases(own_req, next_ack);
  end

endmodule

// File: rtl/tpp_latch_bank.sv
module tpp_latch_bank
  import tpp_pkg::*;
#(
  parameter int BITS = 9
) (
  input  logic            clk,
  input  logic            rst_n,
  input  gate_e           gate,
  input  logic [BITS-1:0] d,
  output logic [BITS-1:0] q
);

  // Sampled model of a level-sensitive bank: while open it follows its input
  // at each sampling edge; while held it keeps the captured word.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (gate == GATE_OPEN) begin
      q <= d;
    end
  end

endmodule

// File: rtl/tpp_stage.sv
module tpp_stage
  import tpp_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             prev_req,
  input  logic [WIDTH-1:0] prev_data,
  input  logic             next_ack,
  output logic             req_q,
  output logic [WIDTH-1:0] data_q
);

  localparam int BUNDLE = WIDTH + 1;

  gate_e             gate;
  logic [BUNDLE-1:0] bundle_d;
  logic [BUNDLE-1:0] bundle_q;

  // Request phase travels in the same bank as the word, keeping them bundled.
  assign bundle_d = {prev_req, prev_data};
  assign req_q    = bundle_q[BUNDLE-1];
  assign data_q   = bundle_q[WIDTH-1:0];

  tpp_stage_ctrl u_ctrl (
    .own_req  (req_q),
    .next_ack (next_ack),
    .gate     (gate)
  );

  tpp_latch_bank #(.BITS(BUNDLE)) u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .gate  (gate),
    .d     (bundle_d),
    .q     (bundle_q)
  );

  // R4: a stage holding an item the successor has not yet taken keeps it.
  assert_full_stage_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q != next_ack) |=> ($stable(req_q) && $stable(data_q)));

  // R3: every phase change of this stage copies the phase offered upstream.
  assert_capture_copies_upstream_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q != $past(req_q)) |-> (req_q == $past(prev_req)));

endmodule

// File: rtl/tpp_pipeline.sv
module tpp_pipeline #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] up_data,
  input  logic             up_req,
  output logic             up_ack,
  output logic [WIDTH-1:0] dn_data,
  output logic             dn_req,
  input  logic             dn_ack
);

  localparam int LAST = DEPTH - 1;

  // Channel k sits in front of stage k; channel DEPTH is the output channel.
  logic [DEPTH:0]   req_chain;
  logic [WIDTH-1:0] data_chain [DEPTH+1];
  logic [DEPTH-1:0] ack_chain;

  assign req_chain[0]  = up_req;
  assign data_chain[0] = up_data;

  for (genvar s = 0; s < DEPTH; s++) begin : g_stage
    if (s == LAST) begin : g_tail
      assign ack_chain[s] = dn_ack;
    end else begin : g_body
      // Successor's captured request doubles as its acknowledge backward.
      assign ack_chain[s] = req_chain[s+2];
    end

    tpp_stage #(.WIDTH(WIDTH)) u_stage (
      .clk       (clk),
      .rst_n     (rst_n),
      .prev_req  (req_chain[s]),
      .prev_data (data_chain[s]),
      .next_ack  (ack_chain[s]),
      .req_q     (req_chain[s+1]),
      .data_q    (data_chain[s+1])
    );
  end

  assign up_ack  = req_chain[1];
  assign dn_req  = req_chain[DEPTH];
  assign dn_data = data_chain[DEPTH];

  // R7: the offered word does not move while the consumer has not taken it.
  assert_out_word_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_req != dn_ack) |=> $stable(dn_data));

  // R8: one offer per word; no second toggle while one is pending.
  assert_single_offer_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_req != dn_ack) |=> $stable(dn_req));

endmodule

// File: tb/tpp_pipeline_tb.sv
module tpp_pipeline_tb;

  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam int N = 4;
  localparam int RAND_ITEMS = 300;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [W-1:0] up_data;
  logic         up_req;
  logic         up_ack;
  logic [W-1:0] dn_data;
  logic         dn_req;
  logic         dn_ack;

  int checks = 0;
  int errors = 0;
  int cycle  = 0;
  logic [W-1:0] exp_mem [512];
  int wr_idx = 0;
  int rd_idx = 0;
  int send_cycle [16];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cycle <= cycle + 1;

  tpp_pipeline #(.WIDTH(W), .DEPTH(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .up_data(up_data), .up_req(up_req), .up_ack(up_ack),
    .dn_data(dn_data), .dn_req(dn_req), .dn_ack(dn_ack)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // Producer: called at a falling edge; waits for the phases to agree.
  task automatic send(input logic [W-1:0] v);
    while (up_req != up_ack) @(negedge clk);
    up_data = v;
    up_req  = ~up_req;
    exp_mem[wr_idx % 512] = v;
    wr_idx++;
  endtask

  // Consumer: waits for a pending word, checks order, then acknowledges.
  task automatic receive(input string tag);
    while (dn_req == dn_ack) @(negedge clk);
    chk(dn_data == exp_mem[rd_idx % 512], tag, dn_data, exp_mem[rd_idx % 512]);
    rd_idx++;
    dn_ack = ~dn_ack;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycle, 0);
    finish_run();
  end

  initial begin
    int cnt;
    int ack_at;
    int accepted;
    logic old_req;
    logic [W-1:0] held;
    bit got;
    void'($urandom(32'h5eed));
    rst_n = 1'b0; up_req = 1'b0; dn_ack = 1'b0; up_data = '0;
    repeat (3) @(negedge clk);
    // R1: idle outputs under reset
    chk(dn_req == 1'b0, "R1 dn_req", dn_req, 0);
    chk(up_ack == 1'b0, "R1 up_ack", up_ack, 0);
    chk(dn_data == '0, "R1 dn_data", dn_data, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 / R3: latency through an empty chain
    old_req = dn_req;
    send(8'hA5);
    cnt = 0; ack_at = 0;
    do begin
      @(negedge clk);
      cnt++;
      if (ack_at == 0 && up_ack == up_req) ack_at = cnt;
    end while (dn_req == old_req && cnt < 50);
    chk(cnt == N, "R2 latency", cnt, N);
    chk(ack_at == 1, "R3 capture ack", ack_at, 1);
    chk(dn_data == 8'hA5, "R2 word", dn_data, 8'hA5);
    receive("R5 first word");
    @(negedge clk);

    // R6: fill against a stalled consumer
    accepted = 0;
    for (int k = 0; k <= N; k++) begin
      send(8'h10 + W'(k));
      got = 1'b0;
      for (int t = 0; t < 30 && !got; t++) begin
        @(negedge clk);
        if (up_ack == up_req) got = 1'b1;
      end
      if (got) accepted++;
      else break;
    end
    chk(accepted == N, "R6 capacity", accepted, N);
    chk(up_ack != up_req, "R6 extra word refused", up_ack, !up_req);
    // R4 / R7 / R8: held word and phase stay put during the stall
    held = dn_data;
    old_req = dn_req;
    repeat (10) @(negedge clk);
    chk(dn_data == held, "R4 held word", dn_data, held);
    chk(dn_req == old_req, "R8 no second offer", dn_req, old_req);
    // R5: ordered drain including the word waiting at the input
    for (int k = 0; k <= N; k++) receive("R5 drain order");
    repeat (3) @(negedge clk);
    chk(up_ack == up_req, "R6 pending word accepted", up_ack, up_req);
    chk(rd_idx == wr_idx, "R5 drained count", rd_idx, wr_idx);
    repeat (4) @(negedge clk);

    // R9: free-flow rate
    fork
      begin
        for (int k = 0; k < 8; k++) begin
          send(8'h40 + W'(k));
          send_cycle[k] = cycle;
        end
      end
      begin
        for (int k = 0; k < 8; k++) receive("R5 stream order");
      end
    join
    for (int k = 2; k < 8; k++)
      chk(send_cycle[k] - send_cycle[k-1] == 2, "R9 interval",
          send_cycle[k] - send_cycle[k-1], 2);
    repeat (4) @(negedge clk);

    // R5: random producer gaps and consumer stalls
    fork
      begin
        for (int k = 0; k < RAND_ITEMS; k++) begin
          repeat ($urandom_range(0, 3)) @(negedge clk);
          send(W'($urandom));
        end
      end
      begin
        for (int k = 0; k < RAND_ITEMS; k++) begin
          if ($urandom_range(0, 9) == 0) repeat (12) @(negedge clk);
          else repeat ($urandom_range(0, 4)) @(negedge clk);
          receive("R5 random order");
        end
      end
    join
    repeat (2 * N + 2) @(negedge clk);
    chk(dn_req == dn_ack, "R8 no stray offer", dn_req, dn_ack);
    chk(rd_idx == wr_idx, "R5 total delivered", rd_idx, wr_idx);
    finish_run();
  end

endmodule